// File: doc/BRIEF.md
# Control-Flow Integrity Monitor

This block watches the retire stream of a simple in-order core and enforces two control-flow rules in hardware. A private return-address stack, which program stores cannot reach, receives the return address of every retired call. Every retired return removes the top entry and compares it with the target the core actually jumped to. An indirect jump or indirect call also arms a landing-pad check: the next instruction that retires must be the designated landing-pad marker.

Each retired instruction arrives as one event with a kind code and two addresses. A violation produces a one-cycle fault pulse with a cause code. After a fault the monitor freezes until software toggles the enable input low and then high again. Holding enable low also empties the stack. The current stack depth and its empty and full flags are always visible.

Top module: `cfi_monitor`

## Requirements
- R1: Out of reset, fault_o is 0, fault_cause_o is 2'b00, stack_depth_o is 0 and stack_empty_o is 1.
- R2: A retired direct call (kind 3'd1) or indirect call (kind 3'd4) pushes retire_ret_addr_i and raises stack_depth_o by one at the edge that samples it.
- R3: A retired return (kind 3'd2) pops the top entry. If retire_target_i equals that entry, no fault occurs. If it differs, the entry is still consumed and a fault with cause 2'b01 is raised.
- R4: Only calls and returns change the stack. Other (3'd0), indirect jump (3'd3) and marker (3'd5) events leave the depth unchanged, and they leave the contents unchanged as seen by later returns.
- R5: After an indirect jump or indirect call, if the next retired instruction is not the marker, a fault with cause 2'b10 is raised and that instruction has no other effect. Cycles with retire_valid_i low do not count as instructions.
- R6: A direct call or direct return arms no landing-pad check. A marker that retires with no check armed has no effect.
- R7: A push with 16 entries already stored, or a pop from an empty stack, raises a fault with cause 2'b11 and leaves the depth unchanged.
- R8: An armed landing-pad check is cleared by the next retired instruction, whether that instruction passes or fails. An instruction after a passing marker is checked normally.
- R9: After a fault, no further fault is raised and the depth stays fixed while enable_i stays high. A cycle with enable_i low clears this frozen state, empties the stack and disarms the landing-pad check.
- R10: fault_o is a single-cycle pulse that appears in the cycle after the event that caused it. fault_cause_o carries the cause during the pulse and 2'b00 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Monitor enable; low clears the stack and the frozen state |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_kind_i | input | 3 | 0 other, 1 call, 2 return, 3 indirect jump, 4 indirect call, 5 marker |
| retire_ret_addr_i | input | AW | Return address pushed by a call |
| retire_target_i | input | AW | Target actually taken by a return |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_cause_o | output | 2 | 01 return mismatch, 10 missing landing pad, 11 stack overflow or underflow |
| stack_depth_o | output | $clog2(DEPTH+1) | Entries held |
| stack_empty_o | output | 1 | Stack holds no entry |
| stack_full_o | output | 1 | Stack holds DEPTH entries |

## Verification
Every result is registered once. The fault pulse, its cause and the new stack depth for an event sampled at a rising edge are all visible right after that edge, and they stay there until the next edge. The bench drives each event on the falling edge and compares all three outputs one time unit after the following rising edge. This makes every event a one-cycle check against the bench's own model. An enable toggle takes one low cycle, and its result, an empty stack, is compared at that same point.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  typedef enum logic [2:0] {
    EV_OTHER = 3'd0,
    EV_CALL  = 3'd1,
    EV_RET   = 3'd2,
    EV_IJMP  = 3'd3,
    EV_ICALL = 3'd4,
    EV_PAD   = 3'd5
  } ev_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'b00,
    FC_RET   = 2'b01,
    FC_PAD   = 2'b10,
    FC_STACK = 2'b11
  } fc_e;
endpackage

// File: rtl/cfi_shadow_stack.sv
module cfi_shadow_stack #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o,
  output logic [CW-1:0] depth_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] mem_q [DEPTH];
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign depth_o = cnt_q;
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (push_i && !full_o)      cnt_q <= cnt_q + CW'(1);
    else if (pop_i && !empty_o)      cnt_q <= cnt_q - CW'(1);
  end

  // entries are written only by pushes; nothing else reaches them
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          mem_q[g] <= '0;
      else if (push_i && !full_o && wr_idx == IW'(g))       mem_q[g] <= push_data_i;
    end
  end
endmodule

// File: rtl/cfi_pad_tracker.sv
module cfi_pad_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic arm_i,
  input  logic retire_i,
  output logic pending_o
);
  logic pend_q;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (flush_i)  pend_q <= 1'b0;
    else if (arm_i)    pend_q <= 1'b1;
    else if (retire_i) pend_q <= 1'b0;
  end
endmodule

// File: rtl/cfi_monitor.sv
module cfi_monitor #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          retire_valid_i,
  input  logic [2:0]    retire_kind_i,
  input  logic [AW-1:0] retire_ret_addr_i,
  input  logic [AW-1:0] retire_target_i,
  output logic          fault_o,
  output logic [1:0]    fault_cause_o,
  output logic [CW-1:0] stack_depth_o,
  output logic          stack_empty_o,
  output logic          stack_full_o
);
  import cfi_pkg::*;

  ev_e           ev;
  fc_e           cause_d;
  logic          active, push, pop, arm, pad_pending, locked_q, fault_q;
  logic [1:0]    cause_q;
  logic [AW-1:0] top;

  cfi_shadow_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (!enable_i),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (retire_ret_addr_i),
    .top_o       (top),
    .depth_o     (stack_depth_o),
    .empty_o     (stack_empty_o),
    .full_o      (stack_full_o)
  );

  cfi_pad_tracker u_pad (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (!enable_i),
    .arm_i     (arm),
    .retire_i  (active),
    .pending_o (pad_pending)
  );

  assign ev     = ev_e'(retire_kind_i);
  assign active = enable_i && retire_valid_i && !locked_q;

  always_comb begin
    cause_d = FC_NONE;
    push    = 1'b0;
    pop     = 1'b0;
    arm     = 1'b0;
    if (active) begin
      if (pad_pending && ev != EV_PAD) begin
        cause_d = FC_PAD;  // landing-pad check wins; instruction otherwise dropped
      end else begin
        case (ev)
          EV_CALL, EV_ICALL: begin
            if (stack_full_o) cause_d = FC_STACK;
            else begin
              push = 1'b1;
              arm  = (ev == EV_ICALL);
            end
          end
          EV_RET: begin
            if (stack_empty_o) cause_d = FC_STACK;
            else begin
              pop = 1'b1;
              if (top != retire_target_i) cause_d = FC_RET;
            end
          end
          EV_IJMP: arm = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q  <= 1'b0;
      cause_q  <= 2'b00;
      locked_q <= 1'b0;
    end else if (!enable_i) begin
      fault_q  <= 1'b0;
      cause_q  <= 2'b00;
      locked_q <= 1'b0;
    end else begin
      fault_q <= (cause_d != FC_NONE);
      cause_q <= cause_d;
      if (cause_d != FC_NONE) locked_q <= 1'b1;
    end
  end

  assign fault_o       = fault_q;
  assign fault_cause_o = cause_q;
endmodule

// File: rtl/cfi_monitor_chk.sv
module cfi_monitor_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          retire_valid_i,
  input logic [2:0]    retire_kind_i,
  input logic          fault_o,
  input logic [1:0]    fault_cause_o,
  input logic [CW-1:0] stack_depth_o,
  input logic          stack_full_o,
  input logic          locked_i,
  input logic          pending_i
);
  logic live;
  assign live = enable_i && retire_valid_i && !locked_i;

  p_depth_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_depth_o <= CW'(DEPTH));

  p_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !pending_i && !stack_full_o && (retire_kind_i == 3'd1 || retire_kind_i == 3'd4))
    |=> stack_depth_o == $past(stack_depth_o) + CW'(1));

  p_no_touch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && retire_valid_i && (retire_kind_i == 3'd0 || retire_kind_i == 3'd3 || retire_kind_i == 3'd5))
    |=> $stable(stack_depth_o));

  p_pad_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && pending_i && retire_kind_i != 3'd5) |=> (fault_o && fault_cause_o == 2'b10));

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && enable_i) |=> (!fault_o && $stable(stack_depth_o)));

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (stack_depth_o == '0 && !fault_o));

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  p_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == (fault_cause_o != 2'b00)));
endmodule

bind cfi_monitor cfi_monitor_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .retire_valid_i (retire_valid_i),
  .retire_kind_i  (retire_kind_i),
  .fault_o        (fault_o),
  .fault_cause_o  (fault_cause_o),
  .stack_depth_o  (stack_depth_o),
  .stack_full_o   (stack_full_o),
  .locked_i       (locked_q),
  .pending_i      (pad_pending)
);

// File: tb/cfi_monitor_test.sv
module cfi_monitor_test;
  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable = 1'b0;
  logic          valid = 1'b0;
  logic [2:0]    kind = 3'd0;
  logic [AW-1:0] ret_addr = '0, target = '0;
  logic          fault;
  logic [1:0]    cause;
  logic [CW-1:0] depth;
  logic          empty, full;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [AW-1:0] m_stk [DEPTH];
  int            m_sp = 0;
  bit            m_pend = 0, m_lock = 0;

  always #10 clk = ~clk;

  cfi_monitor #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable),
    .retire_valid_i(valid), .retire_kind_i(kind),
    .retire_ret_addr_i(ret_addr), .retire_target_i(target),
    .fault_o(fault), .fault_cause_o(cause), .stack_depth_o(depth),
    .stack_empty_o(empty), .stack_full_o(full)
  );

  // expected cause for one event, updating the model
  function automatic logic [1:0] model_step(bit v, logic [2:0] k, logic [AW-1:0] ra, logic [AW-1:0] tg);
    logic [1:0] c = 2'b00;
    if (!v || m_lock) return 2'b00;
    if (m_pend && k != 3'd5) c = 2'b10;
    else begin
      m_pend = 0;
      case (k)
        3'd1, 3'd4: if (m_sp == DEPTH) c = 2'b11;
                    else begin m_stk[m_sp] = ra; m_sp++; if (k == 3'd4) m_pend = 1; end
        3'd2: if (m_sp == 0) c = 2'b11;
              else begin m_sp--; if (m_stk[m_sp] != tg) c = 2'b01; end
        3'd3: m_pend = 1;
        default: ;
      endcase
    end
    if (c == 2'b10) m_pend = 0;
    if (c != 2'b00) m_lock = 1;
    return c;
  endfunction

  task automatic compare(string req, logic [1:0] ec);
    checks++;
    if (fault !== (ec != 2'b00) || cause !== ec || depth !== CW'(m_sp) ||
        empty !== (m_sp == 0) || full !== (m_sp == DEPTH)) begin
      errors++;
      $display("FAIL %s: fault=%0b cause=%0b depth=%0d expected fault=%0b cause=%0b depth=%0d",
               req, fault, cause, depth, ec != 2'b00, ec, m_sp);
    end
  endtask

  task automatic step(string req, bit v, logic [2:0] k, logic [AW-1:0] ra, logic [AW-1:0] tg);
    logic [1:0] ec;
    @(negedge clk);
    valid = v; kind = k; ret_addr = ra; target = tg;
    ec = model_step(v, k, ra, tg);
    @(posedge clk); #1;
    compare(req, ec);
  endtask

  task automatic toggle_en(string req);
    @(negedge clk);
    enable = 1'b0; valid = 1'b0;
    m_sp = 0; m_pend = 0; m_lock = 0;
    @(posedge clk); #1;
    compare(req, 2'b00);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] t;
    void'($urandom(32'h5eed_c0de));
    repeat (2) @(posedge clk);
    #1 compare("R1 reset", 2'b00);
    @(negedge clk); rst_ni = 1'b1; enable = 1'b1;

    step("R2 call push",          1, 3'd1, 32'h100, 0);
    step("R2 indirect call push", 1, 3'd4, 32'h200, 0);
    step("R5 marker after icall", 1, 3'd5, 0, 0);
    step("R3 matching return",    1, 3'd2, 0, 32'h200);
    step("R3 mismatched return",  1, 3'd2, 0, 32'h104);
    step("R9 frozen call",        1, 3'd1, 32'h500, 0);
    step("R9 frozen return",      1, 3'd2, 0, 0);
    toggle_en("R9 enable low empties");

    step("R5 indirect jump",      1, 3'd3, 0, 0);
    step("R5 idle cycle",         0, 3'd0, 0, 0);
    step("R5 missing pad",        1, 3'd0, 0, 0);
    toggle_en("R9 re-enable");
    step("R8 ijmp",               1, 3'd3, 0, 0);
    step("R8 marker",             1, 3'd5, 0, 0);
    step("R8 after pad",          1, 3'd0, 0, 0);
    step("R6 lone marker",        1, 3'd5, 0, 0);
    step("R6 direct call",        1, 3'd1, 32'h300, 0);
    step("R6 no pad needed",      1, 3'd0, 0, 0);
    step("R4 other",              1, 3'd0, 0, 0);
    step("R4 marker",             1, 3'd5, 0, 0);
    step("R4 ijmp",               1, 3'd3, 0, 0);
    step("R4 pad",                1, 3'd5, 0, 0);
    step("R4 return intact",      1, 3'd2, 0, 32'h300);
    step("R5 icall",              1, 3'd4, 32'h400, 0);
    step("R5 call instead of pad",1, 3'd1, 32'h404, 0);
    toggle_en("R9 re-enable");

    for (int i = 0; i < DEPTH; i++) step("R2 fill", 1, 3'd1, 32'h1000 + i * 4, 0);
    step("R7 overflow",           1, 3'd1, 32'h2000, 0);
    toggle_en("R9 clear after overflow");
    step("R7 underflow",          1, 3'd2, 0, 0);
    toggle_en("R9 clear after underflow");

    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 10) != 0;
      logic [2:0] k = 3'($urandom % 6);
      t = (m_sp > 0 && ($urandom % 4) != 0) ? m_stk[m_sp - 1] : $urandom;
      if (m_lock && ($urandom % 3) == 0) toggle_en("R9 random re-enable");
      else step("R3 R5 R10 random", v, k, $urandom, t);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule